// File: doc/BRIEF.md
# Gated Power-of-Two Clock Prescaler

This block derives an output clock from a fast timebase by a programmable power of two and presents it on a pin. The pin is modelled as a data bit and a drive-enable. The clock input runs at twice the rate of the modelled oscillator, so a divider code x gives an output period of 2^(x+1) clock cycles, with a high phase of 2^x cycles and a low phase of 2^x cycles. Codes above 8 act as 8.

Two controls decide whether the pin toggles. The output enable is applied synchronously, and the divider restarts when the output turns on, so the first rising edge always follows after the same delay. Turning the output off waits for the end of a high phase, so no shortened pulse appears. The power-down input passes through a minimum-width filter before it stops the output. Releasing power-down restarts the start-up hold-off, just as reset does. While the pin is inactive, a select bit chooses between a floating pin and a pin driven low.

Top module: `pow2ClockGate`

## Requirements
- R1: With the output active and effective code x, pinData is low for 2^x cycles and then high for 2^x cycles, repeating (code 0 toggles every cycle).
- R2: A divider code of 9 to 15 behaves exactly as code 8 (high and low phases of 256 cycles each).
- R3: If outEnable is sampled high at edge m while the block is ready and inactive, the output becomes active at edge m. pinData stays low after edges m to m+2^x-1 and first goes high after edge m+2^x.
- R4: If outEnable is sampled low while the output is active, the output stays active until the edge that ends a high phase. After that edge the pin is inactive, so the final high phase keeps its full 2^x cycles.
- R5: The divider code is taken only while the output is inactive. A change of divCode while the output is active has no effect on pinData until the output has been switched off and on again.
- R6: After reset is released, the output stays inactive through the first STARTUP_CYCLES (default 512) clock edges. Edge STARTUP_CYCLES+1 is the earliest edge at which the enable is accepted.
- R7: Power-down takes effect only after powerDown has been sampled high on 2^(x+2)+DEGLITCH_CYCLES consecutive edges (two output periods plus the deglitch count, default 6). A shorter pulse leaves pinData and pinDrive unchanged.
- R8: At the edge on which the filtered power-down takes effect, the pin becomes inactive at once. The edge at which powerDown is first sampled low again restarts the start-up hold-off of R6, counted from that edge.
- R9: While inactive, the pin has pinData = 0 and pinDrive = idleLow (0 means high impedance, 1 means driven low), and a change of idleLow shows without a clock delay. While active, pinDrive = 1 regardless of idleLow, and this also holds in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock, twice the modelled oscillator rate |
| rstN | input | 1 | Asynchronous active-low reset |
| divCode | input | 4 | Divider exponent x; values above 8 clamp to 8 |
| outEnable | input | 1 | Request to drive the divided clock on the pin |
| powerDown | input | 1 | Power-down request, filtered by minimum width |
| idleLow | input | 1 | Inactive pin state: 0 floats, 1 drives low |
| pinData | output | 1 | Pin data value |
| pinDrive | output | 1 | Pin drive-enable; 0 means high impedance |

## Verification
The bench counts clock edges from reset release. Each expected pin value is tied to the edge after which it is due: a rising edge 2^x edges after the accepting edge, the switch-off at the first edge whose preceding count closes a high phase, the power-down cut at exactly the 2^(x+2)+DEGLITCH_CYCLES-th high sample, and re-enable STARTUP_CYCLES+1 edges after release. Inputs change just after a falling clock edge, and the monitor compares the pins a moment later, half a cycle away from any active edge. An idleLow change is therefore checked in the same half cycle, while registered effects are checked on the edge number the requirements give.

// File: rtl/pow2GatePkg.sv
package pow2GatePkg;

  localparam int CODE_W = 4;

  typedef enum logic {
    GATE_OFF = 1'b0,
    GATE_ON  = 1'b1
  } gateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              outActive;
    logic [CODE_W-1:0] code;
  } gateCtrl_t;

endpackage

// File: rtl/pow2GateCtrl.sv
module pow2GateCtrl
  import pow2GatePkg::*;
#(
  parameter int MAX_CODE        = 8,
  parameter int STARTUP_CYCLES  = 512,
  parameter int DEGLITCH_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  logic              outEnable,
  input  logic              powerDown,
  input  logic              fallNext,
  output gateCtrl_t         ctrl,
  output logic              pdActive
);

  localparam int SU_W   = $clog2(STARTUP_CYCLES + 1);
  localparam int PD_MAX = (1 << (MAX_CODE + 2)) + DEGLITCH_CYCLES;
  localparam int PD_W   = $clog2(PD_MAX + 1);

  gateState_t        gateState;
  logic [CODE_W-1:0] curCode;
  logic [CODE_W-1:0] clampCode;
  logic [SU_W-1:0]   suCnt;
  logic [PD_W-1:0]   pdCnt;
  logic [PD_W-1:0]   pdThresh;
  logic              ready;
  logic              want;

  assign clampCode = (divCode > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : divCode;

  // two output periods plus the deglitch count, in clock cycles
  assign pdThresh = (PD_W'(1) << (curCode + CODE_W'(2))) + PD_W'(DEGLITCH_CYCLES);
  assign pdActive = (pdCnt >= pdThresh);
  assign ready    = (suCnt == SU_W'(STARTUP_CYCLES));
  assign want     = outEnable && ready && !pdActive;

  // start-up hold-off, restarted by an accepted power-down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suCnt <= '0;
    end else if (pdActive) begin
      suCnt <= '0;
    end else if (!ready) begin
      suCnt <= suCnt + SU_W'(1);
    end
  end

  // power-down width filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdCnt <= '0;
    end else if (!powerDown) begin
      pdCnt <= '0;
    end else if (pdCnt < PD_W'(PD_MAX)) begin
      pdCnt <= pdCnt + PD_W'(1);
    end
  end

  // output gate: on at once, off only when a high phase ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateState <= GATE_OFF;
    end else begin
      case (gateState)
        GATE_OFF: if (want) gateState <= GATE_ON;
        GATE_ON: begin
          if (pdActive) gateState <= GATE_OFF;
          else if (!want && fallNext) gateState <= GATE_OFF;
        end
        default: gateState <= GATE_OFF;
      endcase
    end
  end

  // divider code follows the input only while the gate is closed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCode <= '0;
    end else if (gateState == GATE_OFF) begin
      curCode <= clampCode;
    end
  end

  assign ctrl.outActive = (gateState == GATE_ON) && !pdActive;
  assign ctrl.code      = curCode;

endmodule

// File: rtl/pow2GateData.sv
module pow2GateData
  import pow2GatePkg::*;
#(
  parameter int MAX_CODE = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  gateCtrl_t ctrl,
  input  logic      idleLow,
  output logic      pinData,
  output logic      pinDrive,
  output logic      fallNext
);

  localparam int CW = MAX_CODE + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lowMask;
  logic [CW-1:0] selBit;
  logic          divClk;

  // divider restarts from zero whenever the output is inactive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.outActive) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= '0;
    end
  end

  for (genvar g = 0; g < CW; g++) begin : gSel
    assign lowMask[g] = (ctrl.code >= CODE_W'(g));
    assign selBit[g]  = (ctrl.code == CODE_W'(g));
  end

  assign divClk   = |(cnt & selBit);
  // all counter bits up to the selected one set: divided clock falls next
  assign fallNext = &(cnt | ~lowMask);

  assign pinData  = ctrl.outActive && divClk;
  assign pinDrive = ctrl.outActive || idleLow;

endmodule

// File: rtl/pow2ClockGate.sv
module pow2ClockGate
  import pow2GatePkg::*;
#(
  parameter int MAX_CODE        = 8,
  parameter int STARTUP_CYCLES  = 512,
  parameter int DEGLITCH_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] divCode,
  input  logic              outEnable,
  input  logic              powerDown,
  input  logic              idleLow,
  output logic              pinData,
  output logic              pinDrive
);

  gateCtrl_t ctrlBus;
  logic      fallNext;
  logic      pdActive;

  pow2GateCtrl #(
    .MAX_CODE       (MAX_CODE),
    .STARTUP_CYCLES (STARTUP_CYCLES),
    .DEGLITCH_CYCLES(DEGLITCH_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .divCode  (divCode),
    .outEnable(outEnable),
    .powerDown(powerDown),
    .fallNext (fallNext),
    .ctrl     (ctrlBus),
    .pdActive (pdActive)
  );

  pow2GateData #(
    .MAX_CODE(MAX_CODE)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlBus),
    .idleLow (idleLow),
    .pinData (pinData),
    .pinDrive(pinDrive),
    .fallNext(fallNext)
  );

endmodule

// File: rtl/pow2GateChecker.sv
module pow2GateChecker #(
  parameter int MAX_CODE       = 8,
  parameter int STARTUP_CYCLES = 512
) (
  input logic       clk,
  input logic       rstN,
  input logic       pinData,
  input logic       pinDrive,
  input logic       idleLow,
  input logic       outActive,
  input logic       pdActive,
  input logic [3:0] code
);

  localparam int SU_W = $clog2(STARTUP_CYCLES + 1);

  logic [SU_W-1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst < SU_W'(STARTUP_CYCLES)) sinceRst <= sinceRst + SU_W'(1);
  end

  assert_clamp_R2: assert property (@(posedge clk) disable iff (!rstN)
    code <= 4'(MAX_CODE));

  assert_first_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outActive) |-> !pinData);

  assert_full_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outActive) && !pdActive) |-> $past(pinData));

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outActive && $past(outActive)) |-> $stable(code));

  assert_lockout_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SU_W'(STARTUP_CYCLES)) |-> (!pinData && pinDrive == idleLow));

  assert_pd_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    pdActive |-> (!pinData && pinDrive == idleLow));

  assert_float_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pinDrive |-> !pinData);

endmodule

bind pow2ClockGate pow2GateChecker #(
  .MAX_CODE      (MAX_CODE),
  .STARTUP_CYCLES(STARTUP_CYCLES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .pinData  (pinData),
  .pinDrive (pinDrive),
  .idleLow  (idleLow),
  .outActive(ctrlBus.outActive),
  .pdActive (pdActive),
  .code     (ctrlBus.code)
);

// File: tb/sim_pow2ClockGate.sv
`timescale 1ns/1ps
module sim_pow2ClockGate;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] divCode = 4'd2;
  logic       outEnable = 1'b1;
  logic       powerDown = 1'b0;
  logic       idleLow = 1'b0;
  logic       pinData;
  logic       pinDrive;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  d;
    logic  v;
    string req;
  } expItem_t;

  expItem_t sbq[$];

  pow2ClockGate u0 (
    .clk      (clk),
    .rstN     (rstN),
    .divCode  (divCode),
    .outEnable(outEnable),
    .powerDown(powerDown),
    .idleLow  (idleLow),
    .pinData  (pinData),
    .pinDrive (pinDrive)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic compare(string req, int at, logic ad, logic av, logic ed, logic ev);
    checks++;
    if (ad !== ed || av !== ev) begin
      errors++;
      $display("FAIL %s edge %0d: data/drive actual %b/%b expected %b/%b",
               req, at, ad, av, ed, ev);
    end
  endtask

  task automatic pushOne(int at, logic d, logic v, string req);
    expItem_t it;
    it.at = at; it.d = d; it.v = v; it.req = req;
    sbq.push_back(it);
  endtask

  // expected waveform after edges m+k0 .. m+k1 for an output activated at edge m
  task automatic pushWave(int m, int code, int k0, int k1, string req);
    for (int k = k0; k <= k1; k++) pushOne(m + k, logic'((k >> code) & 1), 1'b1, req);
  endtask

  task automatic waitCyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: compare half a cycle away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
        expItem_t it;
        it = sbq.pop_front();
        if (it.at < cyc) begin
          checks++;
          errors++;
          $display("FAIL %s edge %0d: sample missed, actual edge %0d expected %0d",
                   it.req, it.at, cyc, it.at);
        end else begin
          compare(it.req, it.at, pinData, pinDrive, it.d, it.v);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: inactive, floating (R9)
    compare("R9", 0, pinData, pinDrive, 1'b0, 1'b0);
    rstN = 1'b1;

    pushOne(10, 1'b0, 1'b0, "R6");
    waitCyc(20);
    idleLow = 1'b1;
    pushOne(20, 1'b0, 1'b1, "R9");
    pushOne(512, 1'b0, 1'b1, "R6");
    pushWave(513, 2, 0, 15, "R3");

    waitCyc(528);
    pushWave(513, 2, 16, 47, "R5");
    pushOne(561, 1'b0, 1'b1, "R4");
    pushOne(562, 1'b0, 1'b1, "R4");
    pushOne(566, 1'b0, 1'b1, "R4");
    waitCyc(530);
    divCode = 4'd0;            // ignored while active (R5)
    waitCyc(555);
    outEnable = 1'b0;          // sampled at edge 556, off at 561 (R4)

    waitCyc(570);
    outEnable = 1'b1;          // accepted at edge 571 with code 0
    pushWave(571, 0, 0, 3, "R1");
    pushWave(571, 0, 4, 9, "R9");
    waitCyc(575);
    idleLow = 1'b0;            // no effect while active (R9)

    waitCyc(580);
    pushWave(571, 0, 10, 11, "R4");
    pushOne(583, 1'b0, 1'b0, "R9");
    pushOne(584, 1'b0, 1'b0, "R9");
    waitCyc(582);
    outEnable = 1'b0;          // sampled at 583, high phase ends there

    waitCyc(590);
    divCode = 4'd12;
    idleLow = 1'b1;
    outEnable = 1'b1;          // accepted at edge 591, clamped to 8
    pushOne(590, 1'b0, 1'b1, "R9");
    pushWave(591, 8, 0, 2, "R2");
    pushWave(591, 8, 254, 257, "R2");

    waitCyc(850);
    outEnable = 1'b0;
    pushWave(591, 8, 510, 511, "R4");
    pushOne(1103, 1'b0, 1'b1, "R4");

    waitCyc(1110);
    divCode = 4'd1;
    outEnable = 1'b1;          // accepted at edge 1111
    pushWave(1111, 1, 0, 50, "R7");
    waitCyc(1130);
    powerDown = 1'b1;          // sampled high at edges 1131..1143
    waitCyc(1143);
    powerDown = 1'b0;          // 13 samples < 14: ignored (R7)

    waitCyc(1161);
    pushWave(1111, 1, 51, 72, "R7");
    pushOne(1184, 1'b0, 1'b1, "R8");
    pushOne(1190, 1'b0, 1'b1, "R8");
    pushOne(1201, 1'b0, 1'b1, "R8");
    pushOne(1500, 1'b0, 1'b1, "R8");
    pushOne(1713, 1'b0, 1'b1, "R8");
    pushWave(1714, 1, 0, 5, "R8");
    waitCyc(1170);
    powerDown = 1'b1;          // 14th high sample at edge 1184 (R7)
    waitCyc(1200);
    powerDown = 1'b0;          // first low sample at edge 1201

    waitCyc(1725);
    while (sbq.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule